// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block stamps transitions on an asynchronous input pin with the value of a 16-bit time base that advances once per system clock. The pin is brought into the clock domain by a two-flop synchronizer, and a programmable mode decides which transitions count: each rising transition, each falling transition, every fourth rising transition, or every sixteenth rising transition. When a transition qualifies, the time base value is copied into a capture register, a sticky capture flag goes high, and the time base can optionally be cleared so that the next stamp measures the period directly.

Software-style control comes through strobed write ports. One strobe loads the mode and the clear-on-capture option together. Another strobe loads the time base. A third strobe clears the flag. The time base, the capture register and the flag are always visible on output ports.

The rising-edge divider count is kept when one active mode is replaced by another. Because of this, the first stamp after such a change can arrive early. Writing the disabled code clears the count.

Top module: `edge_stamp_unit`

## Requirements
- R1: The time base adds one on every clock edge and wraps from 16'hFFFF to 16'h0000.
- R2: While rstN is low, and until configured after reset, the time base, capture register and flag read zero, and the mode is disabled, so input transitions cause no capture.
- R3: The input passes through two synchronizing flops and an edge detector. If capIn changes just after clock edge k, the capture happens at edge k+3, and the capture register receives the time base value held between edges k+2 and k+3.
- R4: Mode code 4'b0010 captures on every rising transition, and mode code 4'b0001 captures on every falling transition.
- R5: Mode code 4'b0011 captures on every 4th rising transition, and mode code 4'b0100 captures on every 16th rising transition. In both cases the count starts after the mode is entered from the disabled state.
- R6: Code 4'b0000 and every code not listed in R4 and R5 disable capture and hold the rising-transition count at zero.
- R7: Replacing one active mode with another active mode keeps the rising-transition count. For example, three rises in mode 4'b0100 followed by a switch to 4'b0011 give a capture on the very next rise.
- R8: A capture sets capFlag, which stays set until a flagClr strobe. When a capture and flagClr occur in the same cycle, the flag stays set.
- R9: With clear-on-capture set, the time base reads zero right after the capture edge. With it clear, the time base keeps counting.
- R10: A tbWrEn strobe loads tbWrData into the time base at the next edge. This load wins over clear-on-capture and over the increment, while a coincident capture still records the old time base value.
- R11: A cfgWrEn strobe loads cfgMode and cfgRstEn together. Without the strobe, these inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| capIn | input | 1 | Asynchronous input whose transitions are stamped |
| cfgWrEn | input | 1 | Strobe that loads mode and clear-on-capture option |
| cfgMode | input | 4 | Mode code loaded by cfgWrEn |
| cfgRstEn | input | 1 | Clear-on-capture option loaded by cfgWrEn |
| tbWrEn | input | 1 | Strobe that loads the time base |
| tbWrData | input | 16 | Value loaded into the time base |
| flagClr | input | 1 | Strobe that clears the capture flag |
| tbValue | output | 16 | Current time base value |
| capBuf | output | 16 | Last captured time base value |
| capFlag | output | 1 | Sticky capture flag |

## Verification
The embedded assertions check the following on every cycle:
- the time base increments, is cleared after a capture when clear-on-capture is set, and is loaded by a write (R1, R9, R10);
- the capture register receives the pre-edge time base value;
- the flag sets and clears as specified, including the case where a capture and a clear coincide (R8);
- a rising-mode capture is always preceded by a low-to-high change of the synchronized level;
- the divider count stays at zero while the unit is disabled (R6).

Some behaviour can only be shown by the bench's scenarios, which drive pulse trains through the pin:
- the three-edge latency from pin to capture;
- the divide-by-4 and divide-by-16 spacing of captures;
- the early capture after an active-to-active mode change (R7);
- the absence of capture for the disabled code and the reserved codes.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

  typedef enum logic [3:0] {
    MODE_OFF    = 4'b0000,
    MODE_FALL   = 4'b0001,
    MODE_RISE   = 4'b0010,
    MODE_RISE4  = 4'b0011,
    MODE_RISE16 = 4'b0100
  } modeE;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic capture;
    logic clearTime;
  } stampStrobesT;

endpackage

// File: rtl/edge_stamp_ctrl.sv
module edge_stamp_ctrl
  import edge_stamp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         capIn,
  input  logic         cfgWrEn,
  input  logic [3:0]   cfgMode,
  input  logic         cfgRstEn,
  output stampStrobesT strobes
);

  localparam int CNT_W = $clog2(DIV_HI);
  localparam int LO_W  = $clog2(DIV_LO);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   prevLvl;
  logic                   riseSeen;
  logic                   fallSeen;
  logic [3:0]             modeQ;
  logic                   rstEnQ;
  modeE                   modeSel;
  logic                   modeActive;
  logic [CNT_W-1:0]       riseCnt;
  logic                   hit;

  // synchronizer chain, length chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= capIn;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], capIn};
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncLvl;
  end

  assign riseSeen = syncLvl & ~prevLvl;
  assign fallSeen = ~syncLvl & prevLvl;

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_OFF;
      rstEnQ <= 1'b0;
    end else if (cfgWrEn) begin
      modeQ  <= cfgMode;
      rstEnQ <= cfgRstEn;
    end
  end

  always_comb begin
    case (modeQ)
      MODE_FALL:   modeSel = MODE_FALL;
      MODE_RISE:   modeSel = MODE_RISE;
      MODE_RISE4:  modeSel = MODE_RISE4;
      MODE_RISE16: modeSel = MODE_RISE16;
      default:     modeSel = MODE_OFF;
    endcase
  end

  assign modeActive = (modeSel != MODE_OFF);

  // rising-transition divider; kept across active mode changes
  always_ff @(posedge clk) begin
    if (!rstN)            riseCnt <= '0;
    else if (!modeActive) riseCnt <= '0;
    else if (riseSeen)    riseCnt <= riseCnt + 1'b1;
  end

  always_comb begin
    case (modeSel)
      MODE_RISE:   hit = riseSeen;
      MODE_FALL:   hit = fallSeen;
      MODE_RISE4:  hit = riseSeen && (riseCnt[LO_W-1:0] == {LO_W{1'b1}});
      MODE_RISE16: hit = riseSeen && (riseCnt == {CNT_W{1'b1}});
      default:     hit = 1'b0;
    endcase
  end

  assign strobes.capture   = hit;
  assign strobes.clearTime = hit & rstEnQ;

  // R6
  off_count_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> (riseCnt == '0));

  // R4
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_RISE && strobes.capture) |-> (syncLvl && !$past(syncLvl)));

  // R4
  fall_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_FALL && strobes.capture) |-> (!syncLvl && $past(syncLvl)));

endmodule

// File: rtl/edge_stamp_dp.sv
module edge_stamp_dp
  import edge_stamp_pkg::*;
#(
  parameter int TB_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  stampStrobesT    strobes,
  input  logic            tbWrEn,
  input  logic [TB_W-1:0] tbWrData,
  input  logic            flagClr,
  output logic [TB_W-1:0] timeBase,
  output logic [TB_W-1:0] capReg,
  output logic            flag
);

  // time base: write beats clear-on-capture, which beats increment
  always_ff @(posedge clk) begin
    if (!rstN)                  timeBase <= '0;
    else if (tbWrEn)            timeBase <= tbWrData;
    else if (strobes.clearTime) timeBase <= '0;
    else                        timeBase <= timeBase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                capReg <= '0;
    else if (strobes.capture) capReg <= timeBase;
  end

  // sticky flag, a new capture wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN)                flag <= 1'b0;
    else if (strobes.capture) flag <= 1'b1;
    else if (flagClr)         flag <= 1'b0;
  end

  // R1
  tb_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tbWrEn && !strobes.clearTime) |=> (timeBase == TB_W'($past(timeBase) + 1'b1)));

  // R10
  tb_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    tbWrEn |=> (timeBase == $past(tbWrData)));

  // R9
  tb_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearTime && !tbWrEn) |=> (timeBase == '0));

  // R3
  cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (capReg == $past(timeBase)));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> flag);

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !strobes.capture) |=> !flag);

endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import edge_stamp_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            capIn,
  input  logic            cfgWrEn,
  input  logic [3:0]      cfgMode,
  input  logic            cfgRstEn,
  input  logic            tbWrEn,
  input  logic [TB_W-1:0] tbWrData,
  input  logic            flagClr,
  output logic [TB_W-1:0] tbValue,
  output logic [TB_W-1:0] capBuf,
  output logic            capFlag
);

  stampStrobesT strobes;

  edge_stamp_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DIV_LO     (4),
    .DIV_HI     (16)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .capIn   (capIn),
    .cfgWrEn (cfgWrEn),
    .cfgMode (cfgMode),
    .cfgRstEn(cfgRstEn),
    .strobes (strobes)
  );

  edge_stamp_dp #(
    .TB_W(TB_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .tbWrEn  (tbWrEn),
    .tbWrData(tbWrData),
    .flagClr (flagClr),
    .timeBase(tbValue),
    .capReg  (capBuf),
    .flag    (capFlag)
  );

endmodule

// File: tb/edge_stamp_unit_test.sv
`timescale 1ns/1ps
module edge_stamp_unit_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        capIn;
  logic        cfgWrEn;
  logic [3:0]  cfgMode;
  logic        cfgRstEn;
  logic        tbWrEn;
  logic [15:0] tbWrData;
  logic        flagClr;
  logic [15:0] tbValue;
  logic [15:0] capBuf;
  logic        capFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  edge_stamp_unit uut (
    .clk(clk), .rstN(rstN), .capIn(capIn),
    .cfgWrEn(cfgWrEn), .cfgMode(cfgMode), .cfgRstEn(cfgRstEn),
    .tbWrEn(tbWrEn), .tbWrData(tbWrData), .flagClr(flagClr),
    .tbValue(tbValue), .capBuf(capBuf), .capFlag(capFlag)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic [4:0] pulses;
    logic       expPrev;
    logic       expLast;
  } vecT;

  localparam vecT VECS [8] = '{
    '{4'b0010, 5'd1,  1'b0, 1'b1},  // R4 rising
    '{4'b0001, 5'd1,  1'b0, 1'b1},  // R4 falling
    '{4'b0011, 5'd4,  1'b0, 1'b1},  // R5 every 4th
    '{4'b0100, 5'd16, 1'b0, 1'b1},  // R5 every 16th
    '{4'b0011, 5'd3,  1'b0, 1'b0},  // R5 not yet
    '{4'b0000, 5'd2,  1'b0, 1'b0},  // R6 off
    '{4'b0111, 5'd2,  1'b0, 1'b0},  // R6 reserved
    '{4'b1010, 5'd1,  1'b0, 1'b0}   // R6 reserved
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] m, input logic r);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgMode = m; cfgRstEn = r;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgMode = 4'hF; cfgRstEn = 1'b1;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic pulse();
    capIn = 1'b1;
    repeat (4) @(negedge clk);
    capIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rstN = 1'b0; capIn = 1'b0; cfgWrEn = 1'b0; cfgMode = 4'h0; cfgRstEn = 1'b0;
    tbWrEn = 1'b0; tbWrData = '0; flagClr = 1'b0;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 tb", 32'(tbValue), 0);
    chk("R2 buf", 32'(capBuf), 0);
    chk("R2 flag", 32'(capFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 mode disabled after reset
    pulse();
    chk("R2 no capture", 32'(capFlag), 0);
    // R11 unstrobed config ignored
    cfgMode = 4'b0010; cfgRstEn = 1'b1;
    pulse();
    chk("R11 no strobe", 32'(capFlag), 0);

    // vector table
    foreach (VECS[i]) begin
      cfgWrite(4'b0000, 1'b0);
      clearFlag();
      cfgWrite(VECS[i].mode, 1'b0);
      for (int p = 1; p < int'(VECS[i].pulses); p++) pulse();
      chk($sformatf("vec%0d prev R4/R5/R6", i), 32'(capFlag), 32'(VECS[i].expPrev));
      pulse();
      chk($sformatf("vec%0d last R4/R5/R6", i), 32'(capFlag), 32'(VECS[i].expLast));
    end

    // R1 increment and wrap
    @(negedge clk);
    v = tbValue;
    @(negedge clk);
    chk("R1 step", 32'(tbValue), 32'(16'(v + 1)));
    tbWrEn = 1'b1; tbWrData = 16'hFFFF;
    @(negedge clk);
    tbWrEn = 1'b0;
    chk("R10 write", 32'(tbValue), 32'hFFFF);
    @(negedge clk);
    chk("R1 wrap", 32'(tbValue), 0);

    // R3 + R9 latency and clear-on-capture
    cfgWrite(4'b0000, 1'b0);
    clearFlag();
    cfgWrite(4'b0010, 1'b1);
    v = tbValue; capIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R3 no early flag", 32'(capFlag), 0);
    @(negedge clk);
    chk("R3 buf", 32'(capBuf), 32'(16'(v + 2)));
    chk("R9 cleared", 32'(tbValue), 0);
    chk("R8 set", 32'(capFlag), 1);
    @(negedge clk);
    chk("R9 resume", 32'(tbValue), 1);
    capIn = 1'b0; repeat (4) @(negedge clk);
    clearFlag();
    chk("R8 clear", 32'(capFlag), 0);

    // R9 free-running when option off
    cfgWrite(4'b0010, 1'b0);
    v = tbValue; capIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 buf", 32'(capBuf), 32'(16'(v + 2)));
    chk("R9 running", 32'(tbValue), 32'(16'(v + 3)));
    capIn = 1'b0; repeat (4) @(negedge clk);

    // R10 write wins over clear; R8 capture wins over clear
    cfgWrite(4'b0010, 1'b1);
    clearFlag();
    v = tbValue; capIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tbWrEn = 1'b1; tbWrData = 16'hABCD; flagClr = 1'b1;
    @(negedge clk);
    tbWrEn = 1'b0; flagClr = 1'b0;
    chk("R10 write wins", 32'(tbValue), 32'hABCD);
    chk("R10 buf old", 32'(capBuf), 32'(16'(v + 2)));
    chk("R8 set wins", 32'(capFlag), 1);
    capIn = 1'b0; repeat (4) @(negedge clk);

    // R7 count kept across active mode change
    cfgWrite(4'b0000, 1'b0);
    clearFlag();
    cfgWrite(4'b0100, 1'b0);
    repeat (3) pulse();
    chk("R7 none yet", 32'(capFlag), 0);
    cfgWrite(4'b0011, 1'b0);
    pulse();
    chk("R7 early capture", 32'(capFlag), 1);
    // R6 disable clears count
    cfgWrite(4'b0100, 1'b0);
    repeat (3) pulse();
    cfgWrite(4'b0000, 1'b0);
    clearFlag();
    cfgWrite(4'b0011, 1'b0);
    pulse();
    chk("R6 count cleared", 32'(capFlag), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule